// File: doc/BRIEF.md
# Line Port Loopback and Receive-Output Controller

This block is the digital per-port control layer of a multi-port dual-rail E1 line interface. It is replicated once per port, eight ports by default. On the receive side it takes the recovered positive-rail and negative-rail data and the recovered clock. It then drives the receive rail outputs with a selectable polarity. It also produces a receive clock output, which is the XOR of the two rails and serves a framer that recovers its own clock. A single power-down input disables the receive outputs of every port at once.

Each port has a loopback mode input that models a three-level pin with two signals: a "driven" qualifier and a level bit.

- In local loopback, the port's own transmit data replaces the line data on the receive side.
- In remote loopback, the received rails and the recovered clock are sent back out on the transmit side, and the transmit inputs are ignored.

A digital loss-of-signal detector counts consecutive bit periods in which both rails are idle. Its threshold is programmable and is held inside 10 to 255 bit periods.

Top module: `e1_port_ctrl`

## Requirements
- R1: With `rx_pol_inv`=0 the receive rail outputs equal the internal active-high rails. With `rx_pol_inv`=1 they are their complement.
- R2: While `rx_pdn`=1, `rx_oe` is 0 (the pads are high impedance) and every port's `rx_p_out`, `rx_n_out` and `rx_clk_out` are held at 0. While `rx_pdn`=0, `rx_oe` is 1.
- R3: When powered up, `rx_clk_out` is the XOR of the internal active-high rails, whatever the value of `rx_pol_inv`.
- R4: The mode encoding is: `lb_drv`=0 selects normal, `lb_drv`=1 with `lb_lvl`=1 selects local loopback, and `lb_drv`=1 with `lb_lvl`=0 selects remote loopback. In normal mode the receive side follows the line inputs and the transmit outputs follow the transmit inputs.
- R5: In local loopback the internal receive rails are `tx_p_in`/`tx_n_in` and the line inputs have no effect. The transmit outputs still follow the transmit inputs.
- R6: In remote loopback `tx_p_out`, `tx_n_out` and `tx_clk_out` equal `line_p`, `line_n` and `line_clk`, and the transmit inputs have no effect. The receive outputs still show the line data.
- R7: A mode change takes effect only after the first rising clock edge that samples the new mode inputs. Before that edge the previous routing holds.
- R8: `los` rises after the clock edge that samples the T-th consecutive bit period with both internal rails at 0. T is `los_thresh` clamped to the range 10..255, so values below 10 act as 10.
- R9: `los` clears at the first edge that samples a bit period with either rail at 1. While `los` is high, the receive outputs keep following the rails.
- R10: The detector uses the internal active-high rails. Polarity inversion does not affect it, and in local loopback it watches the transmit data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-period clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_pol_inv | input | 1 | 1 = receive rail outputs active low |
| rx_pdn | input | 1 | Receive power-down, all ports |
| los_thresh | input | 8 | Loss-of-signal run length in bit periods |
| lb_drv | input | NPORTS | Per-port mode pin driven (0 = open) |
| lb_lvl | input | NPORTS | Per-port mode pin level |
| line_p | input | NPORTS | Recovered positive rail |
| line_n | input | NPORTS | Recovered negative rail |
| line_clk | input | NPORTS | Recovered clock |
| tx_p_in | input | NPORTS | Transmit positive rail |
| tx_n_in | input | NPORTS | Transmit negative rail |
| tx_clk_in | input | NPORTS | Transmit clock |
| rx_oe | output | 1 | Receive pad output enable |
| rx_p_out | output | NPORTS | Receive positive rail output |
| rx_n_out | output | NPORTS | Receive negative rail output |
| rx_clk_out | output | NPORTS | Rail-XOR clock output |
| tx_p_out | output | NPORTS | Positive rail to line driver |
| tx_n_out | output | NPORTS | Negative rail to line driver |
| tx_clk_out | output | NPORTS | Clock to line driver |
| los | output | NPORTS | Loss-of-signal flag |

## Verification
The routing is swept over all 16 combinations of the line rails and transmit rails. The sweep covers every mode, both polarities and both power states. Each port is given a different rotation of the pattern, so a swapped rail or a crossed port index shows up as a mismatch. Patterns where the line data and the transmit data disagree show which source a mode picked. Patterns with equal rails separate the XOR clock from a copied rail. The loss-of-signal runs stop one bit period short of the threshold and one period at it, for an in-range threshold and for a clamped one. They also cover an inverted polarity and a local loopback with a quiet line, which shows the detector watches the internal rails.

// File: rtl/e1_port_ctrl_pkg.sv
package e1_port_ctrl_pkg;

   typedef enum logic [1:0] {
      PM_NORMAL = 2'd0,
      PM_LOCAL  = 2'd1,
      PM_REMOTE = 2'd2
   } port_mode_e;

   function automatic port_mode_e mode_decode(input logic drv, input logic lvl);
      if (!drv)     return PM_NORMAL;
      else if (lvl) return PM_LOCAL;
      else          return PM_REMOTE;
   endfunction

endpackage

// File: rtl/e1_mode_reg.sv
module e1_mode_reg
   import e1_port_ctrl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       drv,
   input  logic       lvl,
   output port_mode_e mode_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= PM_NORMAL;
      else        mode_q <= mode_decode(drv, lvl);
   end

   // R7: the routing mode is the one sampled at the previous edge
   a_r7_mode_sampled: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (mode_q == ($past(drv) ? ($past(lvl) ? PM_LOCAL : PM_REMOTE) : PM_NORMAL)));

endmodule

// File: rtl/e1_los_det.sv
module e1_los_det #(
   parameter int CNT_W   = 8,
   parameter int LOS_MIN = 10,
   parameter int LOS_MAX = 255
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rail_p,
   input  logic             rail_n,
   input  logic [CNT_W-1:0] thresh,
   output logic             los
);

   localparam int SUM_W = CNT_W + 1;
   localparam logic [CNT_W-1:0] MIN_V = CNT_W'(LOS_MIN);
   localparam logic [CNT_W-1:0] MAX_V = CNT_W'(LOS_MAX);
   localparam logic [CNT_W-1:0] SAT_V = {CNT_W{1'b1}};

   initial begin
      assert (LOS_MIN >= 1 && LOS_MIN <= LOS_MAX) else $error("bad LOS bounds");
      assert (LOS_MAX < (1 << CNT_W)) else $error("CNT_W too small for LOS_MAX");
   end

   logic [CNT_W-1:0] run_q;
   logic [CNT_W-1:0] eff_thr;
   logic [SUM_W-1:0] run_inc;
   logic             quiet;

   assign quiet   = !(rail_p || rail_n);
   assign run_inc = {1'b0, run_q} + SUM_W'(1);

   always_comb begin
      if (thresh < MIN_V)      eff_thr = MIN_V;
      else if (thresh > MAX_V) eff_thr = MAX_V;
      else                     eff_thr = thresh;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
         los   <= 1'b0;
      end else if (quiet) begin
         run_q <= (run_q == SAT_V) ? SAT_V : run_inc[CNT_W-1:0];
         los   <= (run_inc >= {1'b0, eff_thr});
      end else begin
         run_q <= '0;
         los   <= 1'b0;
      end
   end

   // R9: any active bit clears the flag at the next edge
   a_r9_clear_on_activity: assert property (@(posedge clk) disable iff (!rst_n)
      (rail_p || rail_n) |=> !los);

   // R8: the flag only rises after a quiet bit period
   a_r8_rise_after_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(los) |-> $past(!(rail_p || rail_n)));

endmodule

// File: rtl/e1_port_path.sv
module e1_port_path
   import e1_port_ctrl_pkg::*;
#(
   parameter bit INV_BY_XOR = 1'b1
) (
   input  port_mode_e mode,
   input  logic       pol_inv,
   input  logic       pdn,
   input  logic       line_p,
   input  logic       line_n,
   input  logic       line_clk,
   input  logic       tx_p_in,
   input  logic       tx_n_in,
   input  logic       tx_clk_in,
   output logic       rx_p_int,
   output logic       rx_n_int,
   output logic       rx_p_out,
   output logic       rx_n_out,
   output logic       rx_clk_out,
   output logic       tx_p_out,
   output logic       tx_n_out,
   output logic       tx_clk_out
);

   logic pol_p, pol_n;

   always_comb begin
      if (mode == PM_LOCAL) begin
         rx_p_int = tx_p_in;
         rx_n_int = tx_n_in;
      end else begin
         rx_p_int = line_p;
         rx_n_int = line_n;
      end
   end

   always_comb begin
      if (mode == PM_REMOTE) begin
         tx_p_out   = line_p;
         tx_n_out   = line_n;
         tx_clk_out = line_clk;
      end else begin
         tx_p_out   = tx_p_in;
         tx_n_out   = tx_n_in;
         tx_clk_out = tx_clk_in;
      end
   end

   generate
      if (INV_BY_XOR) begin : g_xor_inv
         assign pol_p = rx_p_int ^ pol_inv;
         assign pol_n = rx_n_int ^ pol_inv;
      end else begin : g_mux_inv
         assign pol_p = pol_inv ? ~rx_p_int : rx_p_int;
         assign pol_n = pol_inv ? ~rx_n_int : rx_n_int;
      end
   endgenerate

   assign rx_p_out   = pdn ? 1'b0 : pol_p;
   assign rx_n_out   = pdn ? 1'b0 : pol_n;
   assign rx_clk_out = pdn ? 1'b0 : (rx_p_int ^ rx_n_int);

endmodule

// File: rtl/e1_port_ctrl.sv
module e1_port_ctrl
   import e1_port_ctrl_pkg::*;
#(
   parameter int NPORTS     = 8,
   parameter int CNT_W      = 8,
   parameter int LOS_MIN    = 10,
   parameter int LOS_MAX    = 255,
   parameter bit INV_BY_XOR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_pol_inv,
   input  logic              rx_pdn,
   input  logic [CNT_W-1:0]  los_thresh,
   input  logic [NPORTS-1:0] lb_drv,
   input  logic [NPORTS-1:0] lb_lvl,
   input  logic [NPORTS-1:0] line_p,
   input  logic [NPORTS-1:0] line_n,
   input  logic [NPORTS-1:0] line_clk,
   input  logic [NPORTS-1:0] tx_p_in,
   input  logic [NPORTS-1:0] tx_n_in,
   input  logic [NPORTS-1:0] tx_clk_in,
   output logic              rx_oe,
   output logic [NPORTS-1:0] rx_p_out,
   output logic [NPORTS-1:0] rx_n_out,
   output logic [NPORTS-1:0] rx_clk_out,
   output logic [NPORTS-1:0] tx_p_out,
   output logic [NPORTS-1:0] tx_n_out,
   output logic [NPORTS-1:0] tx_clk_out,
   output logic [NPORTS-1:0] los
);

   initial begin
      assert (NPORTS >= 1 && NPORTS <= 64) else $error("NPORTS out of range");
   end

   assign rx_oe = !rx_pdn;

   generate
      for (genvar gi = 0; gi < NPORTS; gi++) begin : g_port
         port_mode_e mode_q;
         logic       rp_int, rn_int;

         e1_mode_reg u_mode (
            .clk    (clk),
            .rst_n  (rst_n),
            .drv    (lb_drv[gi]),
            .lvl    (lb_lvl[gi]),
            .mode_q (mode_q)
         );

         e1_port_path #(.INV_BY_XOR(INV_BY_XOR)) u_path (
            .mode       (mode_q),
            .pol_inv    (rx_pol_inv),
            .pdn        (rx_pdn),
            .line_p     (line_p[gi]),
            .line_n     (line_n[gi]),
            .line_clk   (line_clk[gi]),
            .tx_p_in    (tx_p_in[gi]),
            .tx_n_in    (tx_n_in[gi]),
            .tx_clk_in  (tx_clk_in[gi]),
            .rx_p_int   (rp_int),
            .rx_n_int   (rn_int),
            .rx_p_out   (rx_p_out[gi]),
            .rx_n_out   (rx_n_out[gi]),
            .rx_clk_out (rx_clk_out[gi]),
            .tx_p_out   (tx_p_out[gi]),
            .tx_n_out   (tx_n_out[gi]),
            .tx_clk_out (tx_clk_out[gi])
         );

         e1_los_det #(.CNT_W(CNT_W), .LOS_MIN(LOS_MIN), .LOS_MAX(LOS_MAX)) u_los (
            .clk    (clk),
            .rst_n  (rst_n),
            .rail_p (rp_int),
            .rail_n (rn_int),
            .thresh (los_thresh),
            .los    (los[gi])
         );

         // R3: the output clock matches the XOR of the driven rail outputs
         a_r3_clk_xor: assert property (@(posedge clk) disable iff (!rst_n)
            !rx_pdn |-> (rx_clk_out[gi] == (rx_p_out[gi] ^ rx_n_out[gi])));

         // R6: remote loopback sends the line rails back out
         a_r6_remote_echo: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q == PM_REMOTE) |-> (tx_p_out[gi] == line_p[gi] && tx_n_out[gi] == line_n[gi]));

         // R5: local loopback feeds the transmit rails to the receiver
         a_r5_local_feed: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q == PM_LOCAL) |-> (rp_int == tx_p_in[gi] && rn_int == tx_n_in[gi]));
      end
   endgenerate

   // R2: power-down silences every receive output
   a_r2_pdn_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      rx_pdn |-> (!rx_oe && rx_p_out == '0 && rx_n_out == '0 && rx_clk_out == '0));

endmodule

// File: tb/e1_port_ctrl_bench.sv
`timescale 1ns/1ps
module e1_port_ctrl_bench;

   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         rx_pol_inv = 1'b0, rx_pdn = 1'b0;
   logic [7:0]   los_thresh = 8'd12;
   logic [N-1:0] lb_drv = '0, lb_lvl = '0;
   logic [N-1:0] line_p = '0, line_n = '0, line_clk = '0;
   logic [N-1:0] tx_p_in = '0, tx_n_in = '0, tx_clk_in = '0;
   logic         rx_oe;
   logic [N-1:0] rx_p_out, rx_n_out, rx_clk_out, tx_p_out, tx_n_out, tx_clk_out, los;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   e1_port_ctrl u_e1_port_ctrl (
      .clk(clk), .rst_n(rst_n), .rx_pol_inv(rx_pol_inv), .rx_pdn(rx_pdn),
      .los_thresh(los_thresh), .lb_drv(lb_drv), .lb_lvl(lb_lvl),
      .line_p(line_p), .line_n(line_n), .line_clk(line_clk),
      .tx_p_in(tx_p_in), .tx_n_in(tx_n_in), .tx_clk_in(tx_clk_in),
      .rx_oe(rx_oe), .rx_p_out(rx_p_out), .rx_n_out(rx_n_out), .rx_clk_out(rx_clk_out),
      .tx_p_out(tx_p_out), .tx_n_out(tx_n_out), .tx_clk_out(tx_clk_out), .los(los)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic set_mode(input int m);
      @(negedge clk);
      lb_drv = (m == 0) ? '0 : '1;
      lb_lvl = (m == 1) ? '1 : '0;
      @(negedge clk);
   endtask

   task automatic edges(input int k);
      for (int i = 0; i < k; i++) @(negedge clk);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [N-1:0] ep, en, ec, etp, etn, etc, sp, sn;
      edges(3);
      // reset state
      check("R4 reset los", 32'(los), 32'h0);
      check("R4 reset tx follows input", 32'(tx_p_out), 32'(tx_p_in));
      rst_n = 1'b1;
      edges(1);

      // near-exhaustive routing sweep: R1 R2 R3 R4 R5 R6
      for (int m = 0; m < 3; m++) begin
         set_mode(m);
         for (int pol = 0; pol < 2; pol++) begin
            for (int pd = 0; pd < 2; pd++) begin
               for (int v = 0; v < 16; v++) begin
                  @(negedge clk);
                  rx_pol_inv = pol[0];
                  rx_pdn     = pd[0];
                  for (int i = 0; i < N; i++) begin
                     logic [3:0] d;
                     d = 4'(v + i);
                     line_p[i]    = d[0];
                     line_n[i]    = d[1];
                     tx_p_in[i]   = d[2];
                     tx_n_in[i]   = d[3];
                     line_clk[i]  = d[1];
                     tx_clk_in[i] = ~d[0];
                  end
                  #1;
                  sp  = (m == 1) ? tx_p_in : line_p;
                  sn  = (m == 1) ? tx_n_in : line_n;
                  ep  = pd ? '0 : (sp ^ {N{pol[0]}});
                  en  = pd ? '0 : (sn ^ {N{pol[0]}});
                  ec  = pd ? '0 : (sp ^ sn);
                  etp = (m == 2) ? line_p : tx_p_in;
                  etn = (m == 2) ? line_n : tx_n_in;
                  etc = (m == 2) ? line_clk : tx_clk_in;
                  check(m == 1 ? "R5 rx_p" : "R1 rx_p", 32'(rx_p_out), 32'(ep));
                  check(m == 1 ? "R5 rx_n" : "R1 rx_n", 32'(rx_n_out), 32'(en));
                  check("R3 rx_clk", 32'(rx_clk_out), 32'(ec));
                  check("R2 rx_oe", 32'(rx_oe), 32'(!pd));
                  check(m == 2 ? "R6 tx_p" : "R4 tx_p", 32'(tx_p_out), 32'(etp));
                  check(m == 2 ? "R6 tx_n" : "R4 tx_n", 32'(tx_n_out), 32'(etn));
                  check(m == 2 ? "R6 tx_clk" : "R4 tx_clk", 32'(tx_clk_out), 32'(etc));
               end
            end
         end
      end

      // R7: mode change waits for an edge
      set_mode(0);
      rx_pdn = 1'b0; rx_pol_inv = 1'b0;
      line_p = 8'hA5; line_n = 8'h0F; tx_p_in = 8'h3C; tx_n_in = 8'hC3;
      lb_drv = '1; lb_lvl = '0;
      #1;
      check("R7 before edge tx_p", 32'(tx_p_out), 32'h3C);
      @(negedge clk); #1;
      check("R7 after edge tx_p", 32'(tx_p_out), 32'hA5);
      lb_lvl = '1;
      #1;
      check("R7 before edge rx_p", 32'(rx_p_out), 32'hA5);
      @(negedge clk); #1;
      check("R7 after edge rx_p", 32'(rx_p_out), 32'h3C);

      // R8: threshold 12, quiet line in normal mode
      set_mode(0);
      los_thresh = 8'd12;
      line_p = '1; line_n = '0; tx_p_in = '0; tx_n_in = '0;
      edges(2);
      line_p = '0;
      edges(11);
      check("R8 thr12 one short", 32'(los), 32'h0);
      edges(1);
      check("R8 thr12 reached", 32'(los), 32'hFF);
      // R9: outputs still follow during los, then clear
      rx_pol_inv = 1'b1; #1;
      check("R9 rx follows during los", 32'(rx_p_out), 32'hFF);
      rx_pol_inv = 1'b0;
      line_n = 8'h01; edges(1);
      check("R9 clear port0", 32'(los), 32'hFE);
      line_n = '1; edges(1);
      line_n = '0;

      // R8: threshold below minimum clamps to 10
      los_thresh = 8'd3;
      edges(9);
      check("R8 clamp one short", 32'(los), 32'h0);
      edges(1);
      check("R8 clamp reached", 32'(los), 32'hFF);
      line_p = '1; edges(1);
      check("R9 clear all", 32'(los), 32'h0);

      // R10: inverted polarity still counts internal rails
      rx_pol_inv = 1'b1; line_p = '0; los_thresh = 8'd10;
      edges(10);
      check("R10 pol inverted counts", 32'(los), 32'hFF);
      rx_pol_inv = 1'b0;

      // R10: local loopback watches transmit data, not the quiet line
      set_mode(1);
      tx_p_in = 8'h55; tx_n_in = 8'hAA;
      edges(20);
      check("R10 local active tx", 32'(los), 32'h0);
      tx_p_in = '0; tx_n_in = '0;
      edges(10);
      check("R10 local quiet tx", 32'(los), 32'hFF);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule